// File: doc/BRIEF.md
# Cascaded Two-Channel 64-bit Interval Timer

This block chains two identical counter halves into one double-width counter. Both halves run from the block clock, with no prescaler. The lower half counts on every enabled cycle. The upper half takes one step only when the lower half wraps: from all ones to zero when counting up, or from zero to all ones when counting down. The pair is driven by a single set of controls: load, enable, direction, auto-reload and mode. The cascade bit must be set for the pair to count at all. Only one interrupt flag exists.

In generate mode the block loads the concatenated value `{load_hi_i, load_lo_i}`. When the full-width value wraps, the block raises a one-clock pulse and sets the interrupt flag. It then either reloads the value or stops. The lower-half carry, the full-width wrap and the output pulse each pass through a register. This gives an interval of the load distance plus four clocks. A separate one-clock pulse marks every wrap of the lower half.

In capture mode the block samples a trigger through two flops. On the sampled rising edge it latches both halves of the count into the capture register on the same clock edge. Both halves update on a common edge. Software can therefore read a consistent value by reading the upper half, then the lower half, then the upper half again, and retrying while the two upper reads differ.

Top module: `casc_timer`

## Requirements
- R1: The counter moves only while `cascade_i`=1, `enable_i`=1, `load_i`=0, `freeze_i`=0, and a non-reloading run has not finished. Otherwise both halves hold.
- R2: With `load_i`=1, the next clock edge sets the count to `{load_hi_i, load_lo_i}`. The same edge clears any pending carry, pending wrap and finished state.
- R3: The upper half (`cnt_hi_o`) changes only on the clock edge that follows a lower-half wrap, or on a load or reload. Counting up from 0, at t cycles after start the count is lo = t mod 2^W and hi = (t-1) div 2^W for t ≥ 1.
- R4: In generate mode (`capture_mode_i`=0), let D = L when counting down (`count_down_i`=1) and D = 2^(2W)-1-L when counting up, where L is the full load value. The first `gen0_o` pulse comes D+3 cycles after counting starts. Later pulses repeat every D+4 cycles with auto-reload, and the count reads L again one cycle after each pulse.
- R5: `gen0_o` is exactly one clock wide. `gen1_o` gives one one-clock pulse per lower-half wrap, one cycle after that wrap, in generate mode. Per period there are (L div 2^W)+1 such pulses counting down and 2^W-(L div 2^W) counting up.
- R6: With `auto_reload_i`=0, the run stops after its single `gen0_o` pulse. The count then holds at {all ones, all ones minus 2} counting down, or {0, 2} counting up, until the next load.
- R7: Each cycle that `freeze_i` is high holds the count and the whole wrap pipeline, which delays the pulse by the same number of cycles.
- R8: `int_flag_o` is set by a `gen0` event or a capture event. It is cleared by `irq_clr_i`, and a set wins over a clear in the same cycle. `irq_o` equals `int_flag_o` AND `irq_en_i`.
- R9: In capture mode, a rising edge of the trigger (active high by default), sampled through two flops, copies both halves of the count into `{cap_hi_o, cap_lo_o}` on one edge. This happens only while `cascade_i`, `enable_i` and not `load_i` hold, and the flag is set.
- R10: With `auto_reload_i`=0, a captured value is kept until `cap_read_i` pulses; later triggers still set the flag. With `auto_reload_i`=1, every trigger overwrites the captured value.
- R11: `gen_en_i`=0 silences `gen0_o` and `gen1_o`, while the reload and the interrupt flag behave as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_lo_i | input | CNT_W | Lower half of the load value |
| load_hi_i | input | CNT_W | Upper half of the load value |
| cascade_i | input | 1 | Cascade enable, required for counting |
| enable_i | input | 1 | Run enable |
| load_i | input | 1 | Force load of the full load value |
| auto_reload_i | input | 1 | 1: reload / overwrite, 0: stop / keep |
| count_down_i | input | 1 | 1: count down, 0: count up |
| capture_mode_i | input | 1 | 1: capture mode, 0: generate mode |
| gen_en_i | input | 1 | Enable for the generate pulse outputs |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| cap_read_i | input | 1 | Marks the captured value as read |
| trig_i | input | 1 | Capture trigger |
| freeze_i | input | 1 | Halts counting |
| cnt_lo_o | output | CNT_W | Lower half of the count |
| cnt_hi_o | output | CNT_W | Upper half of the count |
| cap_lo_o | output | CNT_W | Lower half of the captured value |
| cap_hi_o | output | CNT_W | Upper half of the captured value |
| gen0_o | output | 1 | Full-width wrap pulse |
| gen1_o | output | 1 | Lower-half wrap pulse |
| int_flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the count holds under freeze, with cascade off, and after a stopping pulse;
- the upper half moves only after a registered lower-half carry or a reload;
- the full-wrap pulse lasts a single cycle and always leaves the flag set;
- a clear without a concurrent event empties the flag.

The bench scenarios cover what needs a history: the exact interval in both directions over a sweep of load values, the number of lower-half wrap pulses per period, the frozen end values of a stopped run, and the staggered upper-half step. They also cover the capture keep, re-arm and overwrite sequence.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
  localparam int unsigned N_HALVES = 2;
endpackage

// File: rtl/casc_half.sv
module casc_half
  import casc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  dir_e         dir_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONES = '1;
  logic [W-1:0] val_q;

  assign wrap_o = step_i & ((dir_i == DIR_DOWN) ? (val_q == '0) : (val_q == ONES));
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (ld_i)   val_q <= ld_val_i;
    else if (step_i) val_q <= (dir_i == DIR_DOWN) ? val_q - 1'b1 : val_q + 1'b1;
  end
endmodule

// File: rtl/casc_capture.sv
module casc_capture #(
  parameter int unsigned W2            = 64,
  parameter bit          TRIG_ACT_HIGH = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          arm_i,
  input  logic          overwrite_i,
  input  logic          read_i,
  input  logic [W2-1:0] cnt_i,
  output logic          evt_o,
  output logic [W2-1:0] cap_o
);
  logic trig_n, s1_q, s2_q, full_q, wr;
  logic [W2-1:0] cap_q;

  assign trig_n = TRIG_ACT_HIGH ? trig_i : ~trig_i;
  assign evt_o  = arm_i & s1_q & ~s2_q;
  assign wr     = evt_o & (overwrite_i | ~full_q);
  assign cap_o  = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= trig_n;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      full_q <= 1'b0;
    end else if (wr) begin
      cap_q  <= cnt_i;
      full_q <= 1'b1;
    end else if (read_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/casc_seq.sv
module casc_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  input  logic freeze_i,
  input  logic gen_mode_i,
  input  logic auto_i,
  input  logic lo_wrap_i,
  input  logic hi_wrap_i,
  input  logic cap_evt_i,
  input  logic irq_clr_i,
  output logic adv_o,
  output logic fire_o,
  output logic carry_o,
  output logic flag_o
);
  logic carry_q, evt_q, gen_q, done_q, flag_q, restart;

  assign adv_o   = run_i & ~freeze_i & ~done_q;
  assign fire_o  = gen_q & adv_o;
  assign restart = load_i | (fire_o & auto_i);
  assign carry_o = carry_q;
  assign flag_o  = flag_q;

  // carry -> full wrap -> pulse stage, each registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      evt_q   <= 1'b0;
      gen_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (restart) begin
      carry_q <= 1'b0;
      evt_q   <= 1'b0;
      gen_q   <= 1'b0;
      if (load_i) done_q <= 1'b0;
    end else if (adv_o) begin
      carry_q <= lo_wrap_i;
      evt_q   <= hi_wrap_i & gen_mode_i;
      gen_q   <= evt_q;
      if (fire_o) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   flag_q <= 1'b0;
    else if (fire_o || cap_evt_i)  flag_q <= 1'b1;
    else if (irq_clr_i)            flag_q <= 1'b0;
  end
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import casc_pkg::*;
#(
  parameter int unsigned CNT_W         = 32,
  parameter bit          TRIG_ACT_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] load_lo_i,
  input  logic [CNT_W-1:0] load_hi_i,
  input  logic             cascade_i,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic             auto_reload_i,
  input  logic             count_down_i,
  input  logic             capture_mode_i,
  input  logic             gen_en_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             cap_read_i,
  input  logic             trig_i,
  input  logic             freeze_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic [CNT_W-1:0] cap_lo_o,
  output logic [CNT_W-1:0] cap_hi_o,
  output logic             gen0_o,
  output logic             gen1_o,
  output logic             int_flag_o,
  output logic             irq_o
);
  localparam int unsigned FULL_W = 2 * CNT_W;

  logic run, adv, fire, carry_q, reload, ld, cap_evt;
  dir_e dir;
  logic [N_HALVES-1:0]            step, wrap;
  logic [N_HALVES-1:0][CNT_W-1:0] ld_val, val;
  logic [FULL_W-1:0]              cap;

  assign run     = cascade_i & enable_i & ~load_i;
  assign dir     = count_down_i ? DIR_DOWN : DIR_UP;
  assign reload  = fire & auto_reload_i;
  assign ld      = load_i | reload;
  assign step[0] = adv & ~fire;
  assign step[1] = adv & carry_q & ~fire;
  assign ld_val[0] = load_lo_i;
  assign ld_val[1] = load_hi_i;

  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    casc_half #(.W(CNT_W)) i_half (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld),
      .ld_val_i (ld_val[g]),
      .step_i   (step[g]),
      .dir_i    (dir),
      .val_o    (val[g]),
      .wrap_o   (wrap[g])
    );
  end

  casc_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .run_i      (run),
    .freeze_i   (freeze_i),
    .gen_mode_i (~capture_mode_i),
    .auto_i     (auto_reload_i),
    .lo_wrap_i  (wrap[0]),
    .hi_wrap_i  (wrap[1]),
    .cap_evt_i  (cap_evt),
    .irq_clr_i  (irq_clr_i),
    .adv_o      (adv),
    .fire_o     (fire),
    .carry_o    (carry_q),
    .flag_o     (int_flag_o)
  );

  casc_capture #(.W2(FULL_W), .TRIG_ACT_HIGH(TRIG_ACT_HIGH)) i_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .arm_i       (run & capture_mode_i),
    .overwrite_i (auto_reload_i),
    .read_i      (cap_read_i),
    .cnt_i       ({val[1], val[0]}),
    .evt_o       (cap_evt),
    .cap_o       (cap)
  );

  assign cnt_lo_o = val[0];
  assign cnt_hi_o = val[1];
  assign cap_lo_o = cap[CNT_W-1:0];
  assign cap_hi_o = cap[FULL_W-1:CNT_W];
  assign gen0_o   = gen_en_i & fire;
  assign gen1_o   = gen_en_i & ~capture_mode_i & adv & carry_q;
  assign irq_o    = int_flag_o & irq_en_i;
endmodule

// File: rtl/casc_timer_chk.sv
module casc_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic         cascade_i,
  input logic         freeze_i,
  input logic         auto_reload_i,
  input logic         irq_clr_i,
  input logic [W-1:0] cnt_lo_o,
  input logic [W-1:0] cnt_hi_o,
  input logic         gen0_o,
  input logic         int_flag_o,
  input logic         fire_i,
  input logic         carry_i,
  input logic         cap_evt_i
);
  assert_cascade_off_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cascade_i && !load_i) |=> $stable({cnt_hi_o, cnt_lo_o}));

  assert_hi_after_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !carry_i && !fire_i) |=> $stable(cnt_hi_o));

  assert_gen0_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen0_o |=> !gen0_o);

  assert_stop_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !auto_reload_i && !load_i) |=> $stable({cnt_hi_o, cnt_lo_o}));

  assert_freeze_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !load_i) |=> $stable({cnt_hi_o, cnt_lo_o}));

  assert_gen_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen0_o |=> int_flag_o);

  assert_clear_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !fire_i && !cap_evt_i) |=> !int_flag_o);
endmodule

bind casc_timer casc_timer_chk #(.W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_i        (load_i),
  .cascade_i     (cascade_i),
  .freeze_i      (freeze_i),
  .auto_reload_i (auto_reload_i),
  .irq_clr_i     (irq_clr_i),
  .cnt_lo_o      (cnt_lo_o),
  .cnt_hi_o      (cnt_hi_o),
  .gen0_o        (gen0_o),
  .int_flag_o    (int_flag_o),
  .fire_i        (fire),
  .carry_i       (carry_q),
  .cap_evt_i     (cap_evt)
);

// File: tb/test_casc_timer.sv
module test_casc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int FW         = 2 * W;
  localparam int FMAX       = (1 << FW) - 1;
  localparam int HSPAN      = 1 << W;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] load_lo_i, load_hi_i, cnt_lo_o, cnt_hi_o, cap_lo_o, cap_hi_o;
  logic cascade_i, enable_i, load_i, auto_reload_i, count_down_i, capture_mode_i;
  logic gen_en_i, irq_en_i, irq_clr_i, cap_read_i, trig_i, freeze_i;
  logic gen0_o, gen1_o, int_flag_o, irq_o;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  casc_timer #(.CNT_W(W)) i_casc_timer (
    .clk_i(clk), .rst_ni(rst_ni), .load_lo_i(load_lo_i), .load_hi_i(load_hi_i),
    .cascade_i(cascade_i), .enable_i(enable_i), .load_i(load_i),
    .auto_reload_i(auto_reload_i), .count_down_i(count_down_i),
    .capture_mode_i(capture_mode_i), .gen_en_i(gen_en_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .cap_read_i(cap_read_i), .trig_i(trig_i),
    .freeze_i(freeze_i), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
    .cap_lo_o(cap_lo_o), .cap_hi_o(cap_hi_o), .gen0_o(gen0_o), .gen1_o(gen1_o),
    .int_flag_o(int_flag_o), .irq_o(irq_o)
  );

  function automatic int cnt();
    return int'({cnt_hi_o, cnt_lo_o});
  endfunction

  function automatic int capv();
    return int'({cap_hi_o, cap_lo_o});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WD_LIMIT, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic idle();
    cascade_i = 1'b1; enable_i = 1'b0; load_i = 1'b0; auto_reload_i = 1'b1;
    count_down_i = 1'b1; capture_mode_i = 1'b0; gen_en_i = 1'b1; irq_en_i = 1'b1;
    irq_clr_i = 1'b0; cap_read_i = 1'b0; trig_i = 1'b0; freeze_i = 1'b0;
    load_lo_i = '0; load_hi_i = '0;
  endtask

  // load L, then start counting; returns at negedge t=0
  task automatic start(input int lval);
    @(negedge clk);
    load_lo_i = lval[W-1:0]; load_hi_i = lval[FW-1:W];
    load_i = 1'b1; enable_i = 1'b0;
    @(negedge clk);
    chk(cnt() == lval, "R2 load value", cnt(), lval);
    load_i = 1'b0; enable_i = 1'b1;
  endtask

  task automatic clear_flag();
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic gen_sweep(input bit down);
    for (int lval = 0; lval <= FMAX; lval += 5) begin
      int d, p0, p1, n1, rv;
      d = down ? lval : FMAX - lval;
      p0 = -1; p1 = -1; n1 = 0; rv = -1;
      count_down_i = down; auto_reload_i = 1'b1;
      start(lval);
      for (int t = 0; t <= 2 * d + 8; t++) begin
        if (t > 0) @(negedge clk);
        if (gen0_o) begin
          if (p0 < 0) p0 = t; else if (p1 < 0) p1 = t;
        end
        if (gen1_o && p0 >= 0 && p1 < 0 && t > p0) n1++;
        if (gen1_o && p1 == t) n1++;
        if (t == d + 4) rv = cnt();
      end
      chk(p0 == d + 3, "R4 first pulse", p0, d + 3);
      chk(p1 - p0 == d + 4, "R4 period", p1 - p0, d + 4);
      chk(rv == lval, "R4 reload value", rv, lval);
      chk(n1 == (down ? (lval / HSPAN) + 1 : HSPAN - lval / HSPAN), "R5 lower wraps",
          n1, down ? (lval / HSPAN) + 1 : HSPAN - lval / HSPAN);
    end
  endtask

  initial begin
    int pos, npulse, rec, snap;
    idle();
    repeat (3) @(negedge clk);
    chk(cnt() == 0 && gen0_o == 0 && irq_o == 0 && capv() == 0 && int_flag_o == 0,
        "R2 reset state", cnt(), 0);
    rst_ni = 1'b1;

    // R4 R5 sweeps
    gen_sweep(1'b1);
    gen_sweep(1'b0);

    // R1 cascade off
    cascade_i = 1'b0;
    start(8'h40);
    enable_i = 1'b1;
    npulse = 0;
    for (int t = 0; t < 20; t++) begin @(negedge clk); npulse += gen0_o; end
    chk(cnt() == 8'h40 && npulse == 0, "R1 cascade off holds", cnt(), 8'h40);
    cascade_i = 1'b1;

    // R6 hold mode down and up
    for (int m = 0; m < 2; m++) begin
      int lv, exp;
      lv = m == 0 ? 8'h23 : 8'hE0;
      exp = m == 0 ? 8'hFD : 8'h02;
      count_down_i = (m == 0); auto_reload_i = 1'b0;
      clear_flag();
      start(lv);
      npulse = 0;
      for (int t = 0; t < 300; t++) begin @(negedge clk); npulse += gen0_o; end
      chk(npulse == 1, "R6 single pulse", npulse, 1);
      chk(cnt() == exp, "R6 held value", cnt(), exp);
      chk(int_flag_o == 1 && irq_o == 1, "R8 flag set by pulse", int_flag_o, 1);
    end

    // R8 enable and clear
    irq_en_i = 1'b0;
    #1 chk(irq_o == 0 && int_flag_o == 1, "R8 irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    clear_flag();
    chk(int_flag_o == 0 && irq_o == 0, "R8 flag cleared", int_flag_o, 0);

    // R7 freeze
    auto_reload_i = 1'b1; count_down_i = 1'b1;
    start(8'h30);
    pos = -1;
    for (int t = 0; t < 80; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 10) begin freeze_i = 1'b1; snap = cnt(); end
      if (t == 16) chk(cnt() == snap, "R7 frozen count", cnt(), snap);
      if (t == 17) freeze_i = 1'b0;
      if (gen0_o && pos < 0) pos = t;
    end
    chk(pos == 8'h30 + 3 + 7, "R7 delayed pulse", pos, 8'h30 + 10);

    // R11 pulses silenced
    gen_en_i = 1'b0;
    clear_flag();
    start(5);
    npulse = 0;
    rec = -1;
    for (int t = 0; t <= 9; t++) begin
      if (t > 0) @(negedge clk);
      npulse += gen0_o + gen1_o;
      if (t == 9) rec = cnt();
    end
    chk(npulse == 0, "R11 no pulses", npulse, 0);
    chk(int_flag_o == 1 && rec == 5, "R11 flag and reload", rec, 5);
    gen_en_i = 1'b1;

    // R3 staggered upper step, capture mode up count
    capture_mode_i = 1'b1; count_down_i = 1'b0;
    start(0);
    for (int t = 0; t < 120; t++) begin
      int e;
      if (t > 0) @(negedge clk);
      e = ((t == 0 ? 0 : (t - 1) / HSPAN) % HSPAN) * HSPAN + (t % HSPAN);
      chk(cnt() == e, "R3 staggered count", cnt(), e);
    end

    // R9 R10 capture
    auto_reload_i = 1'b0;
    clear_flag();
    trig_i = 1'b1;
    @(negedge clk); rec = cnt();
    @(negedge clk);
    chk(capv() == rec && int_flag_o == 1, "R9 capture both halves", capv(), rec);
    snap = rec;
    trig_i = 1'b0;
    repeat (3) @(negedge clk);
    clear_flag();
    trig_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(capv() == snap && int_flag_o == 1, "R10 kept until read", capv(), snap);
    trig_i = 1'b0; cap_read_i = 1'b1;
    @(negedge clk); cap_read_i = 1'b0;
    repeat (2) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk); rec = cnt();
    @(negedge clk);
    chk(capv() == rec, "R10 rearmed by read", capv(), rec);
    auto_reload_i = 1'b1; trig_i = 1'b0;
    repeat (3) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk); rec = cnt();
    @(negedge clk);
    chk(capv() == rec, "R10 overwrite", capv(), rec);
    trig_i = 1'b0;
    enable_i = 1'b0;
    repeat (3) @(negedge clk);
    clear_flag();
    snap = capv();
    trig_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(capv() == snap && int_flag_o == 0, "R9 no capture when disabled", capv(), snap);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule